// File: doc/BRIEF.md
# Bidirectional Bus-Matching FIFO Pair

This block joins an 18-bit Port A to a 9-bit Port B through two separate first-in first-out buffers, one for each direction. Neither buffer shares storage with the other. Each buffer holds 18-bit words. In the A-to-B direction every word leaves Port B as two 9-bit lanes. In the B-to-A direction two 9-bit lanes received on Port B are packed into one word before it reaches Port A. Each 9-bit lane holds eight data bits in bits [7:0] and an odd-parity bit in bit 8. Parity is regenerated for lanes that leave Port B and checked for lanes that arrive on it.

Port A can also send a byte straight to Port B over a bypass path, without storing it in either buffer. Port B can set a mark in either buffer and later return to it. Reread replays the read data from the marked word onward. Rewrite rolls the write position back to the mark, so that a block can be written again. Both ports are synchronous to one clock and use valid/ready strobes. The only flags the block exposes are the raw empty and full of each buffer.

The Port B read lane sequencer is a state machine with two states. LANE_LO drives the low lane of the head word. LANE_HI drives the high lane. A transfer in LANE_LO moves the machine to LANE_HI. A transfer in LANE_HI pops the word and returns the machine to LANE_LO. A reread returns it to LANE_LO. The Port B write packer uses the same two states: LANE_LO waits for the first lane and LANE_HI waits for the second. An accepted lane in LANE_LO latches the low half and moves the machine to LANE_HI. An accepted lane in LANE_HI commits the word and returns the machine to LANE_LO. A rewrite returns it to LANE_LO and drops any half-built word.

Top module: `bidir_busmatch_fifo`

## Requirements
- R1: A Port A write (`a_wr_valid`) stores the word in the A-to-B buffer when that buffer is not full. `a_wr_ready` equals the inverse of `ab_full`. A write while the buffer is full is ignored, and the 512 words already held are read out unchanged.
- R2: A-to-B words leave Port B low lane first and high lane second. The low lane carries word bits [7:0] in `b_rd_data[7:0]`. The high lane carries word bits [16:9]. The word is removed from the buffer only when its high lane is taken.
- R3: Every lane that leaves Port B has bit 8 set so that the nine bits hold an odd number of ones. Bits 8 and 17 of the stored word are not used for this.
- R4: On Port B writes, the first accepted lane becomes word bits [8:0] and the second becomes bits [17:9]. The word enters the B-to-A buffer only after the second lane, so `ba_empty` stays high after a lone first lane.
- R5: A Port B lane whose nine bits hold an even number of ones sets `b_par_err`. The flag stays set until reset, and the lane is still stored.
- R6: While `a_byp_valid` is high, Port B shows `{odd parity, a_byp_data}` with `b_rd_valid` and `b_rd_bypass` high, and the A-to-B buffer is not read in that cycle. `a_byp_ready` follows `b_rd_ready`.
- R7: `b_rd_mark` saves the A-to-B read position. A later `b_rd_reread` restores it and resets the lane state, so the next Port B output is the low lane of the marked word.
- R8: `b_wr_mark` saves the B-to-A write position. A later `b_wr_rewrite` restores it and drops a half-packed word, and `b_wr_ready` is low in the rewrite cycle.
- R9: The B-to-A buffer is read on Port A with `a_rd_valid`, `a_rd_data` and `a_rd_ready`. A read while the buffer is empty is ignored.
- R10: After reset both buffers are empty and not full, `b_par_err` is low, and `b_rd_valid` and `a_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_valid | input | 1 | Port A word offered to A-to-B buffer |
| a_wr_data | input | 18 | Port A write word |
| a_wr_ready | output | 1 | A-to-B buffer can take a word |
| a_rd_ready | input | 1 | Port A takes the B-to-A head word |
| a_rd_valid | output | 1 | B-to-A buffer has a word |
| a_rd_data | output | 18 | B-to-A head word |
| a_byp_valid | input | 1 | Bypass byte offered to Port B |
| a_byp_data | input | 8 | Bypass byte |
| a_byp_ready | output | 1 | Bypass byte taken this cycle |
| b_rd_ready | input | 1 | Port B takes the shown lane |
| b_rd_valid | output | 1 | Port B lane is valid |
| b_rd_data | output | 9 | Port B outgoing lane with parity in bit 8 |
| b_rd_bypass | output | 1 | Shown lane comes from the bypass |
| b_rd_mark | input | 1 | Save A-to-B read position |
| b_rd_reread | input | 1 | Restore A-to-B read position |
| b_wr_valid | input | 1 | Port B lane offered |
| b_wr_data | input | 9 | Port B incoming lane with parity in bit 8 |
| b_wr_ready | output | 1 | Port B lane can be taken |
| b_wr_mark | input | 1 | Save B-to-A write position |
| b_wr_rewrite | input | 1 | Restore B-to-A write position |
| b_par_err | output | 1 | Sticky incoming parity error |
| ab_empty | output | 1 | A-to-B buffer empty |
| ab_full | output | 1 | A-to-B buffer full |
| ba_empty | output | 1 | B-to-A buffer empty |
| ba_full | output | 1 | B-to-A buffer full |

## Verification
The bench fills each buffer to 512 words and then writes once more. A design that wraps its pointer on that extra write loses a whole buffer of data or reports the buffer as empty. A bypass byte is driven while a word is half sent, which catches a design that lets the bypass advance the lane state and so sends the high lane twice or skips it. Reread and rewrite are tested from a mark placed mid-stream and with a half-packed word pending. A design that keeps the old lane state would send a high lane first after a reread, or would pair a stale low lane with new data after a rewrite. A lane with bad parity is sent, and the bench then checks that the flag stays set and that the byte is still stored, not dropped.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Parity bit that gives a lane an odd count of ones
    function automatic logic odd_bit(input logic [7:0] d);
        return ~^d;
    endfunction

endpackage

// File: rtl/bbf_fifo_core.sv
module bbf_fifo_core #(
    parameter int WORD_W = 18,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_mark,
    input  logic              wr_restore,
    input  logic              rd_en,
    input  logic              rd_mark,
    input  logic              rd_restore,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW:0] wr_ptr, rd_ptr, wr_mark_ptr, rd_mark_ptr, fill;
    logic        do_wr, do_rd;

    assign fill    = wr_ptr - rd_ptr;
    assign empty   = (fill == '0);
    assign full    = (fill == FULL_CNT);
    assign do_wr   = wr_en && !full && !wr_restore;
    assign do_rd   = rd_en && !empty && !rd_restore;
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr      <= '0;
            rd_ptr      <= '0;
            wr_mark_ptr <= '0;
            rd_mark_ptr <= '0;
        end else begin
            if (wr_mark) wr_mark_ptr <= wr_ptr;
            if (rd_mark) rd_mark_ptr <= rd_ptr;
            if (wr_restore)  wr_ptr <= wr_mark_ptr;
            else if (do_wr)  wr_ptr <= wr_ptr + 1'b1;
            if (rd_restore)  rd_ptr <= rd_mark_ptr;
            else if (do_rd)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !wr_restore) |=> $stable(wr_ptr));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !rd_restore) |=> $stable(rd_ptr));
    // R7
    rd_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_restore |=> (rd_ptr == $past(rd_mark_ptr)));
    // R8
    wr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_restore |=> (wr_ptr == $past(wr_mark_ptr)));

endmodule

// File: rtl/bbf_b_tx.sv
module bbf_b_tx
    import bbf_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_empty,
    input  logic [2*LANE_W-1:0]   fifo_head,
    input  logic                  byp_valid,
    input  logic [LANE_W-2:0]     byp_data,
    input  logic                  b_ready,
    input  logic                  reread,
    output logic                  b_valid,
    output logic [LANE_W-1:0]     b_data,
    output logic                  b_bypass,
    output logic                  pop
);
    lane_e             state, state_nx;
    logic              advance;
    logic [LANE_W-2:0] lane;
    logic              unused_stored_par;

    assign unused_stored_par = fifo_head[LANE_W-1] ^ fifo_head[2*LANE_W-1];
    assign advance = !byp_valid && !reread && !fifo_empty && b_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LANE_LO;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (reread) begin
            state_nx = LANE_LO;
        end else if (advance) begin
            unique case (state)
                LANE_LO: state_nx = LANE_HI;
                LANE_HI: state_nx = LANE_LO;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            LANE_LO: lane = fifo_head[LANE_W-2:0];
            LANE_HI: lane = fifo_head[2*LANE_W-2:LANE_W];
        endcase
        pop = advance && (state == LANE_HI);
        if (byp_valid) begin
            b_valid  = 1'b1;
            b_bypass = 1'b1;
            b_data   = {odd_bit(byp_data), byp_data};
        end else begin
            b_valid  = !fifo_empty && !reread;
            b_bypass = 1'b0;
            b_data   = {odd_bit(lane), lane};
        end
    end

    // R6
    byp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_valid && !reread) |=> (state == $past(state)));
    // R2
    pop_ends_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state == LANE_LO));

endmodule

// File: rtl/bbf_b_rx.sv
module bbf_b_rx
    import bbf_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                b_valid,
    input  logic [LANE_W-1:0]   b_data,
    input  logic                full,
    input  logic                rewrite,
    output logic                b_ready,
    output logic                push,
    output logic [2*LANE_W-1:0] push_word,
    output logic                par_err
);
    lane_e             state, state_nx;
    logic [LANE_W-1:0] lo_q;
    logic              accept;

    assign accept = b_valid && !full && !rewrite;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LANE_LO;
            lo_q    <= '0;
            par_err <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept && state == LANE_LO) lo_q <= b_data;
            if (accept && !(^b_data)) par_err <= 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        if (rewrite) begin
            state_nx = LANE_LO;
        end else if (accept) begin
            unique case (state)
                LANE_LO: state_nx = LANE_HI;
                LANE_HI: state_nx = LANE_LO;
            endcase
        end
    end

    always_comb begin
        b_ready   = !full && !rewrite;
        push      = accept && (state == LANE_HI);
        push_word = {b_data, lo_q};
    end

    // R5
    sticky_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);
    // R4
    push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state == LANE_LO));

endmodule

// File: rtl/bidir_busmatch_fifo.sv
module bidir_busmatch_fifo #(
    parameter int LANE_W = 9,
    parameter int DEPTH  = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_wr_valid,
    input  logic [2*LANE_W-1:0] a_wr_data,
    output logic                a_wr_ready,
    input  logic                a_rd_ready,
    output logic                a_rd_valid,
    output logic [2*LANE_W-1:0] a_rd_data,
    input  logic                a_byp_valid,
    input  logic [LANE_W-2:0]   a_byp_data,
    output logic                a_byp_ready,
    input  logic                b_rd_ready,
    output logic                b_rd_valid,
    output logic [LANE_W-1:0]   b_rd_data,
    output logic                b_rd_bypass,
    input  logic                b_rd_mark,
    input  logic                b_rd_reread,
    input  logic                b_wr_valid,
    input  logic [LANE_W-1:0]   b_wr_data,
    output logic                b_wr_ready,
    input  logic                b_wr_mark,
    input  logic                b_wr_rewrite,
    output logic                b_par_err,
    output logic                ab_empty,
    output logic                ab_full,
    output logic                ba_empty,
    output logic                ba_full
);
    localparam int WORD_W = 2 * LANE_W;

    logic [WORD_W-1:0] ab_head, ba_word;
    logic              ab_pop, ba_push;

    assign a_wr_ready  = !ab_full;
    assign a_rd_valid  = !ba_empty;
    assign a_byp_ready = b_rd_ready;

    bbf_fifo_core #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(a_wr_valid), .wr_data(a_wr_data),
        .wr_mark(1'b0), .wr_restore(1'b0),
        .rd_en(ab_pop), .rd_mark(b_rd_mark), .rd_restore(b_rd_reread),
        .rd_data(ab_head), .empty(ab_empty), .full(ab_full)
    );

    bbf_fifo_core #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ba (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ba_push), .wr_data(ba_word),
        .wr_mark(b_wr_mark), .wr_restore(b_wr_rewrite),
        .rd_en(a_rd_ready), .rd_mark(1'b0), .rd_restore(1'b0),
        .rd_data(a_rd_data), .empty(ba_empty), .full(ba_full)
    );

    bbf_b_tx #(.LANE_W(LANE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(ab_empty), .fifo_head(ab_head),
        .byp_valid(a_byp_valid), .byp_data(a_byp_data),
        .b_ready(b_rd_ready), .reread(b_rd_reread),
        .b_valid(b_rd_valid), .b_data(b_rd_data),
        .b_bypass(b_rd_bypass), .pop(ab_pop)
    );

    bbf_b_rx #(.LANE_W(LANE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .b_valid(b_wr_valid), .b_data(b_wr_data),
        .full(ba_full), .rewrite(b_wr_rewrite),
        .b_ready(b_wr_ready), .push(ba_push),
        .push_word(ba_word), .par_err(b_par_err)
    );

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (ab_empty && ba_empty && !b_par_err));

endmodule

// File: tb/bidir_busmatch_fifo_tb.sv
`timescale 1ns/1ps
module bidir_busmatch_fifo_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        a_wr_valid = 0, a_rd_ready = 0, a_byp_valid = 0;
    logic [17:0] a_wr_data = '0;
    logic [7:0]  a_byp_data = '0;
    logic        b_rd_ready = 0, b_rd_mark = 0, b_rd_reread = 0;
    logic        b_wr_valid = 0, b_wr_mark = 0, b_wr_rewrite = 0;
    logic [8:0]  b_wr_data = '0;
    logic        a_wr_ready, a_rd_valid, a_byp_ready, b_rd_valid, b_rd_bypass;
    logic        b_wr_ready, b_par_err, ab_empty, ab_full, ba_empty, ba_full;
    logic [17:0] a_rd_data;
    logic [8:0]  b_rd_data;

    bidir_busmatch_fifo u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr_valid(a_wr_valid), .a_wr_data(a_wr_data), .a_wr_ready(a_wr_ready),
        .a_rd_ready(a_rd_ready), .a_rd_valid(a_rd_valid), .a_rd_data(a_rd_data),
        .a_byp_valid(a_byp_valid), .a_byp_data(a_byp_data), .a_byp_ready(a_byp_ready),
        .b_rd_ready(b_rd_ready), .b_rd_valid(b_rd_valid), .b_rd_data(b_rd_data),
        .b_rd_bypass(b_rd_bypass), .b_rd_mark(b_rd_mark), .b_rd_reread(b_rd_reread),
        .b_wr_valid(b_wr_valid), .b_wr_data(b_wr_data), .b_wr_ready(b_wr_ready),
        .b_wr_mark(b_wr_mark), .b_wr_rewrite(b_wr_rewrite), .b_par_err(b_par_err),
        .ab_empty(ab_empty), .ab_full(ab_full), .ba_empty(ba_empty), .ba_full(ba_full)
    );

    int checks = 0, errors = 0;

    // reference model
    logic [17:0] mab [512];
    logic [17:0] mba [512];
    int ab_wp = 0, ab_rp = 0, ab_rmark = 0, ab_lane = 0;
    int ba_wp = 0, ba_rp = 0, ba_wmark = 0, ba_half = 0;
    logic [8:0] ba_lo = '0;
    logic m_perr = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] lane9(input logic [7:0] d);
        return {~^d, d};
    endfunction

    task automatic compare();
        int ab_cnt, ba_cnt;
        logic [17:0] hw;
        logic [7:0] ed;
        logic ev;
        ab_cnt = ab_wp - ab_rp;
        ba_cnt = ba_wp - ba_rp;
        chk(ab_empty == (ab_cnt == 0), "R1 ab_empty", ab_empty, ab_cnt == 0);
        chk(ab_full == (ab_cnt == 512), "R1 ab_full", ab_full, ab_cnt == 512);
        chk(a_wr_ready == (ab_cnt != 512), "R1 a_wr_ready", a_wr_ready, ab_cnt != 512);
        chk(ba_empty == (ba_cnt == 0), "R9 ba_empty", ba_empty, ba_cnt == 0);
        chk(ba_full == (ba_cnt == 512), "R9 ba_full", ba_full, ba_cnt == 512);
        chk(a_rd_valid == (ba_cnt != 0), "R9 a_rd_valid", a_rd_valid, ba_cnt != 0);
        if (ba_cnt != 0)
            chk(a_rd_data == mba[ba_rp % 512], "R4 a_rd_data", a_rd_data, mba[ba_rp % 512]);
        chk(b_wr_ready == (ba_cnt != 512 && !b_wr_rewrite), "R8 b_wr_ready",
            b_wr_ready, ba_cnt != 512 && !b_wr_rewrite);
        chk(b_par_err == m_perr, "R5 b_par_err", b_par_err, m_perr);
        ev = a_byp_valid || (ab_cnt != 0 && !b_rd_reread);
        chk(b_rd_valid == ev, "R6 b_rd_valid", b_rd_valid, ev);
        chk(b_rd_bypass == a_byp_valid, "R6 b_rd_bypass", b_rd_bypass, a_byp_valid);
        chk(a_byp_ready == b_rd_ready, "R6 a_byp_ready", a_byp_ready, b_rd_ready);
        if (ev) begin
            if (a_byp_valid) ed = a_byp_data;
            else begin
                hw = mab[ab_rp % 512];
                ed = (ab_lane == 0) ? hw[7:0] : hw[16:9];
            end
            chk(b_rd_data == lane9(ed), "R2 b_rd_data", b_rd_data, lane9(ed));
            chk(^b_rd_data == 1'b1, "R3 odd parity", b_rd_data, lane9(b_rd_data[7:0]));
        end
    endtask

    task automatic update();
        int ab_cnt, ba_cnt, rp_old, wp_old;
        ab_cnt = ab_wp - ab_rp;
        ba_cnt = ba_wp - ba_rp;
        rp_old = ab_rp;
        wp_old = ba_wp;
        if (a_wr_valid && ab_cnt < 512) begin
            mab[ab_wp % 512] = a_wr_data;
            ab_wp++;
        end
        if (b_rd_reread) begin
            ab_rp = ab_rmark;
            ab_lane = 0;
        end else if (!a_byp_valid && ab_cnt != 0 && b_rd_ready) begin
            if (ab_lane == 1) begin ab_rp++; ab_lane = 0; end
            else ab_lane = 1;
        end
        if (b_rd_mark) ab_rmark = rp_old;
        if (b_wr_rewrite) begin
            ba_wp = ba_wmark;
            ba_half = 0;
        end else if (b_wr_valid && ba_cnt < 512) begin
            if (^b_wr_data == 1'b0) m_perr = 1'b1;
            if (ba_half == 1) begin
                mba[ba_wp % 512] = {b_wr_data, ba_lo};
                ba_wp++;
                ba_half = 0;
            end else begin
                ba_lo = b_wr_data;
                ba_half = 1;
            end
        end
        if (b_wr_mark) ba_wmark = wp_old;
        if (a_rd_ready && ba_cnt != 0) ba_rp++;
    endtask

    task automatic step();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic a_write(input logic [17:0] w);
        a_wr_valid = 1; a_wr_data = w; step(); a_wr_valid = 0;
    endtask
    task automatic b_read(input int n);
        b_rd_ready = 1; repeat (n) step(); b_rd_ready = 0;
    endtask
    task automatic b_write(input logic [8:0] l);
        b_wr_valid = 1; b_wr_data = l; step(); b_wr_valid = 0;
    endtask
    task automatic a_read(input int n);
        a_rd_ready = 1; repeat (n) step(); a_rd_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk(ab_empty && ba_empty && !ab_full && !ba_full, "R10 flags",
            {ab_empty, ba_empty, ab_full, ba_full}, 4'b1100);
        chk(!b_par_err && !b_rd_valid && !a_rd_valid, "R10 outputs",
            {b_par_err, b_rd_valid, a_rd_valid}, 3'b000);
        @(negedge clk);
        step();

        // R2 R3: several word patterns, stored parity bits set oddly
        a_write(18'h3_FFFF); a_write(18'h0_0000); a_write(18'h2_A855); a_write(18'h1_2345);
        b_read(3);
        // R6 bypass in the middle of a word
        a_byp_valid = 1; a_byp_data = 8'hC3; b_rd_ready = 1; step();
        #1;
        chk(b_rd_bypass && b_rd_data == lane9(8'h5A) == 0 || b_rd_data == lane9(8'hC3),
            "R6 bypass data", b_rd_data, lane9(8'hC3));
        a_byp_data = 8'h00; step();
        a_byp_valid = 0; b_rd_ready = 0; step();
        b_read(5);
        step();

        // R4 R5: packing and parity check
        b_write(lane9(8'h11));
        #1; chk(ba_empty == 1'b1, "R4 half word not committed", ba_empty, 1'b1);
        b_write(lane9(8'hEE));
        #1; chk(a_rd_data == {lane9(8'hEE), lane9(8'h11)}, "R4 packed word",
            a_rd_data, {lane9(8'hEE), lane9(8'h11)});
        b_write({~lane9(8'h07)[8], 8'h07});
        b_write(lane9(8'h80));
        #1; chk(b_par_err == 1'b1, "R5 error flagged", b_par_err, 1'b1);
        a_read(3);
        #1; chk(b_par_err == 1'b1, "R5 flag sticky", b_par_err, 1'b1);
        // R9 read on empty
        a_read(2);
        #1; chk(ba_empty && !a_rd_valid, "R9 empty read ignored", {ba_empty, a_rd_valid}, 2'b10);

        // R7 mark and reread
        a_write(18'h0_1234); a_write(18'h2_5678); a_write(18'h1_9ABC);
        b_rd_mark = 1; step(); b_rd_mark = 0;
        b_read(3);
        b_rd_reread = 1; step(); b_rd_reread = 0;
        #1; chk(b_rd_data == lane9(8'h34), "R7 reread low lane", b_rd_data, lane9(8'h34));
        b_read(6);

        // R8 mark and rewrite with a half-packed word pending
        b_wr_mark = 1; step(); b_wr_mark = 0;
        b_write(lane9(8'hAA)); b_write(lane9(8'hBB)); b_write(lane9(8'hCC));
        b_wr_rewrite = 1; step(); b_wr_rewrite = 0;
        b_write(lane9(8'h01)); b_write(lane9(8'h02));
        #1; chk(a_rd_data == {lane9(8'h02), lane9(8'h01)}, "R8 rewritten word",
            a_rd_data, {lane9(8'h02), lane9(8'h01)});
        a_read(2);

        // R1 fill A-to-B, write once more, drain
        for (int i = 0; i < 513; i++) a_write(18'((i * 1237 + 5) ^ (i << 9)));
        #1; chk(ab_full == 1'b1, "R1 full after fill", ab_full, 1'b1);
        b_read(1030);
        // fill B-to-A and overflow
        for (int i = 0; i < 1026; i++) b_write(lane9(8'(i * 7 + 3)));
        #1; chk(ba_full == 1'b1, "R9 full after fill", ba_full, 1'b1);
        a_read(514);
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule